// File: doc/BRIEF.md
# Status Summary and Service-Request Generator

This block gathers the event reporting of a bus-attached instrument into one service-request line. Five event status words hold sticky event bits: instrument, display, input, error and standard event. Each word has its own enable mask. Each word is reduced to one summary bit of a poll status byte. The poll status byte is masked by a poll enable register. A new enabled summary raises a latched request flag, and that flag drives the request output.

The host side uses plain strobes. A word read returns the selected word and clears it. An enable write loads one of the masks. A serial-poll strobe takes the latched request flag down. Two byte views are always present on the outputs:

- The poll view shows the latched flag in bit 6.
- The query view shows, in bit 6, whether any enabled summary is set at that moment.

Events arrive as single-cycle pulses on one flat bus, eight bits per word.

Top module: `stat_summary_top`

## Requirements
- R1: The request output can only rise after a cycle in which some poll status bit and the same bit of the poll enable register were both 1.
- R2: A request is raised when the masked poll status vector gains a bit that was 0 in the cycle before. An enabled summary that stays set produces exactly one request.
- R3: A summary bit is the OR of its word ANDed with that word's enable mask. The bit positions in the poll byte are: word 0 (instrument) in bit 0, word 1 (display) in bit 1, word 2 (input) in bit 2, word 3 (error) in bit 3, word 4 (standard event) in bit 5. Bits 4 and 7 read 0.
- R4: Several enabled bits of one word that are set together or one after another raise a single request.
- R5: A word read (rd_sel 0 to 4) returns the word's current value on rd_data and clears the word at the next edge. Writing 0 to that word's enable mask also drops its summary bit.
- R6: A summary source can raise another request only after its summary bit has been 0. This can happen through a read or through an enable clear followed by a re-enable.
- R7: poll_byte bit 6 is the latched request flag. A serial-poll strobe clears it at the next edge, and later polls show 0 until a new request arises.
- R8: query_byte bit 6 is 1 exactly when any summary bit is set together with its poll enable bit. It does not depend on the latched flag.
- R9: Bit 6 of the poll enable register (en_sel 5) always reads as 0 internally. Writing only bit 6 enables nothing and raises no request.
- R10: An event pulse that arrives in the same cycle as a read of its word is kept set after the read.
- R11: After reset, all words, masks, the request flag and the rise history are 0, so srq, poll_byte and query_byte are 0.
- R12: srq equals poll_byte bit 6 and holds until a serial poll.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_i | input | 40 | Event pulses, word k in bits [8k+7:8k] |
| rd_stb | input | 1 | Read-and-clear strobe |
| rd_sel | input | 3 | Word selected for reading (0 to 4) |
| rd_data | output | 8 | Contents of the selected word |
| en_wr | input | 1 | Enable-mask write strobe |
| en_sel | input | 3 | Mask target: 0 to 4 event words, 5 poll enable |
| en_wdata | input | 8 | Mask write data |
| spoll_stb | input | 1 | Serial-poll strobe, clears the request flag |
| poll_byte | output | 8 | Poll view, bit 6 is the latched flag |
| query_byte | output | 8 | Query view, bit 6 is the live master summary |
| srq | output | 1 | Service request line |

## Verification
The bench applies stimulus in several patterns, and each pattern separates a correct request generator from a faulty one:

- A single event followed by repeated events on the same bit shows whether the block is edge-triggered or level-triggered.
- Bursts of several bits, in one pulse and spread over cycles, show that a word raises one request and not one per bit.
- Re-arming after a read, and re-arming after an enable clear and re-enable, shows that the rise history follows the masked summary.
- A poll-enable write of bit 6 alone, and a read that collides with an event pulse, check the two corner cases.
- Comparing poll_byte with query_byte after a serial poll shows that the two meanings of bit 6 are kept apart.

// File: rtl/stat_pkg.sv
// Package: shared sizes and the word-to-summary bit placement.
// Assumes five event words of eight bits each; bit 6 of the poll byte is reserved.
package stat_pkg;
    localparam int NUM_WORDS = 5;
    localparam int WORD_W    = 8;
    localparam int SEL_W     = 3;
    localparam int REQ_BIT   = 6;
    localparam int POLL_EN_SEL = NUM_WORDS;

    // Summary bit position of event word k in the poll byte.
    function automatic int sum_pos(input int k);
        return (k < 4) ? k : k + 1;
    endfunction
endpackage

// File: rtl/stat_event_word.sv
// Module: one sticky event status word with its enable mask and summary bit.
// Assumes single-cycle event pulses; a read clears the word but keeps same-cycle events.
module stat_event_word
    import stat_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt_i,
    input  logic         rd_clr_i,
    input  logic         en_wr_i,
    input  logic [W-1:0] en_wdata_i,
    output logic [W-1:0] word_o,
    output logic         summary_o
);
    logic [W-1:0] word_q;
    logic [W-1:0] en_q;

    // Sticky event capture with read-clear; new pulses win over the clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            word_q <= '0;
        else
            word_q <= (rd_clr_i ? '0 : word_q) | evt_i;
    end

    // Enable mask load.
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= '0;
        else if (en_wr_i)
            en_q <= en_wdata_i;
    end

    // Summary is the OR of enabled event bits.
    always_comb begin
        word_o    = word_q;
        summary_o = |(word_q & en_q);
    end

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_clr_i |=> ((word_q & $past(word_q)) == $past(word_q))); // R10
    AST_READ_KEEPS_EVT: assert property (@(posedge clk) disable iff (!rst_n)
        rd_clr_i |=> (word_q == $past(evt_i))); // R10
endmodule

// File: rtl/stat_srq_gen.sv
// Module: poll enable register, rise detection of the masked summary, request flag.
// Assumes the summary vector is already placed in poll-byte bit order.
module stat_srq_gen
    import stat_pkg::*;
#(
    parameter int W = WORD_W,
    parameter int RB = REQ_BIT
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] summary_i,
    input  logic         pen_wr_i,
    input  logic [W-1:0] pen_wdata_i,
    input  logic         spoll_i,
    output logic         req_o,
    output logic         live_o
);
    localparam logic [W-1:0] REQ_MASK = W'(1) << RB;

    logic [W-1:0] pen_q;
    logic [W-1:0] prev_q;
    logic [W-1:0] enabled;
    logic         rise;
    logic         req_q;

    // Poll enable load; the request bit position is never storable.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pen_q <= '0;
        else if (pen_wr_i)
            pen_q <= pen_wdata_i & ~REQ_MASK;
    end

    // Masked summary and its new-bit detection.
    always_comb begin
        enabled = summary_i & pen_q;
        rise    = |(enabled & ~prev_q);
        live_o  = |enabled;
        req_o   = req_q;
    end

    // Rise history of the masked summary.
    always_ff @(posedge clk) begin
        if (!rst_n)
            prev_q <= '0;
        else
            prev_q <= enabled;
    end

    // Request flag: set on a rise, cleared by serial poll; a rise wins.
    always_ff @(posedge clk) begin
        if (!rst_n)
            req_q <= 1'b0;
        else if (rise)
            req_q <= 1'b1;
        else if (spoll_i)
            req_q <= 1'b0;
    end

    AST_REQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_q) |-> $past(|(summary_i & pen_q))); // R1
    AST_STEADY_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_q && (enabled == prev_q)) |=> !req_q); // R2
    AST_POLL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (spoll_i && (enabled == prev_q)) |=> !req_q); // R7
    AST_PEN_REQ_BIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        pen_wr_i |=> !pen_q[RB]); // R9
endmodule

// File: rtl/stat_summary_top.sv
// Module: top of the status summary unit; five event words feed the request generator.
// Assumes host strobes are one cycle wide and rd_sel/en_sel are valid with their strobes.
module stat_summary_top
    import stat_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_WORDS*WORD_W-1:0]   evt_i,
    input  logic                          rd_stb,
    input  logic [SEL_W-1:0]              rd_sel,
    output logic [WORD_W-1:0]             rd_data,
    input  logic                          en_wr,
    input  logic [SEL_W-1:0]              en_sel,
    input  logic [WORD_W-1:0]             en_wdata,
    input  logic                          spoll_stb,
    output logic [WORD_W-1:0]             poll_byte,
    output logic [WORD_W-1:0]             query_byte,
    output logic                          srq
);
    logic [NUM_WORDS-1:0][WORD_W-1:0] words;
    logic [NUM_WORDS-1:0]             sums;
    logic [WORD_W-1:0]                sum_byte;
    logic                             req;
    logic                             live;

    // One instance per event word.
    for (genvar k = 0; k < NUM_WORDS; k++) begin : g_word
        stat_event_word #(.W(WORD_W)) u_word (
            .clk        (clk),
            .rst_n      (rst_n),
            .evt_i      (evt_i[k*WORD_W +: WORD_W]),
            .rd_clr_i   (rd_stb && (rd_sel == SEL_W'(k))),
            .en_wr_i    (en_wr && (en_sel == SEL_W'(k))),
            .en_wdata_i (en_wdata),
            .word_o     (words[k]),
            .summary_o  (sums[k])
        );
    end

    // Place each word summary in its poll-byte bit.
    always_comb begin
        sum_byte = '0;
        for (int k = 0; k < NUM_WORDS; k++)
            sum_byte[sum_pos(k)] = sums[k];
    end

    stat_srq_gen #(.W(WORD_W), .RB(REQ_BIT)) u_srq (
        .clk         (clk),
        .rst_n       (rst_n),
        .summary_i   (sum_byte),
        .pen_wr_i    (en_wr && (en_sel == SEL_W'(POLL_EN_SEL))),
        .pen_wdata_i (en_wdata),
        .spoll_i     (spoll_stb),
        .req_o       (req),
        .live_o      (live)
    );

    // Read mux and the two byte views.
    always_comb begin
        rd_data = '0;
        for (int k = 0; k < NUM_WORDS; k++)
            if (rd_sel == SEL_W'(k)) rd_data = words[k];
        poll_byte           = sum_byte;
        poll_byte[REQ_BIT]  = req;
        query_byte          = sum_byte;
        query_byte[REQ_BIT] = live;
        srq                 = req;
    end

    AST_SRQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (srq && !spoll_stb) |=> srq); // R12
    AST_SPARE_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !poll_byte[4] && !poll_byte[7] && !query_byte[4] && !query_byte[7]); // R3
endmodule

// File: tb/tb_stat_summary_top.sv
module tb_stat_summary_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [39:0] evt_i = '0;
    logic        rd_stb = 1'b0;
    logic [2:0]  rd_sel = '0;
    logic [7:0]  rd_data;
    logic        en_wr = 1'b0;
    logic [2:0]  en_sel = '0;
    logic [7:0]  en_wdata = '0;
    logic        spoll_stb = 1'b0;
    logic [7:0]  poll_byte;
    logic [7:0]  query_byte;
    logic        srq;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    stat_summary_top dut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .rd_stb(rd_stb), .rd_sel(rd_sel),
        .rd_data(rd_data), .en_wr(en_wr), .en_sel(en_sel), .en_wdata(en_wdata),
        .spoll_stb(spoll_stb), .poll_byte(poll_byte), .query_byte(query_byte), .srq(srq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_en(input int sel, input logic [7:0] v);
        en_wr = 1'b1; en_sel = 3'(sel); en_wdata = v;
        cyc(1);
        en_wr = 1'b0;
    endtask

    task automatic pulse(input int k, input logic [7:0] bits);
        evt_i[k*8 +: 8] = bits;
        cyc(1);
        evt_i = '0;
    endtask

    task automatic rd(input int k, output logic [7:0] v);
        rd_stb = 1'b1; rd_sel = 3'(k);
        #1 v = rd_data;
        cyc(1);
        rd_stb = 1'b0;
    endtask

    task automatic spoll(output logic [7:0] v);
        spoll_stb = 1'b1;
        #1 v = poll_byte;
        cyc(1);
        spoll_stb = 1'b0;
    endtask

    task automatic t_reset;
        chk("R11 srq", {7'd0, srq}, 8'h00);
        chk("R11 poll", poll_byte, 8'h00);
        chk("R11 query", query_byte, 8'h00);
        chk("R11 word", rd_data, 8'h00);
    endtask

    task automatic t_single;
        logic [7:0] v;
        wr_en(0, 8'h01); wr_en(5, 8'h01);
        pulse(0, 8'h01); cyc(1);
        chk("R1 srq after trigger", {7'd0, srq}, 8'h01);
        chk("R12 poll bit6 = srq", poll_byte, 8'h41);
        spoll(v);
        chk("R7 poll value", v, 8'h41);
        chk("R7 after poll", poll_byte, 8'h01);
        spoll(v);
        chk("R7 second poll", v, 8'h01);
        pulse(0, 8'h01); cyc(3);
        chk("R2 repeat event no new request", {7'd0, srq}, 8'h00);
        rd(0, v);
        chk("R5 read value", v, 8'h01);
        chk("R5 cleared", query_byte, 8'h00);
        pulse(0, 8'h01); cyc(1);
        chk("R6 rearm after read", {7'd0, srq}, 8'h01);
        spoll(v); rd(0, v);
    endtask

    task automatic t_multi;
        logic [7:0] v;
        wr_en(3, 8'hFF); wr_en(5, 8'h08);
        pulse(3, 8'h0F); cyc(1);
        pulse(3, 8'h30); cyc(2);
        chk("R4 one request", {7'd0, srq}, 8'h01);
        spoll(v);
        chk("R4 poll", v, 8'h48);
        cyc(2);
        chk("R4 no second request", {7'd0, srq}, 8'h00);
        chk("R8 query live after poll", query_byte, 8'h48);
        chk("R8 poll view after poll", poll_byte, 8'h08);
        rd(3, v);
        chk("R5 multi read", v, 8'h3F);
        chk("R8 query idle", query_byte, 8'h00);
    endtask

    task automatic t_pen6;
        logic [7:0] v;
        wr_en(5, 8'h40); wr_en(1, 8'hFF);
        pulse(1, 8'h80); cyc(2);
        chk("R9 no request", {7'd0, srq}, 8'h00);
        chk("R9 query", query_byte, 8'h02);
        rd(1, v);
    endtask

    task automatic t_enclear;
        logic [7:0] v;
        wr_en(2, 8'h04); wr_en(5, 8'h04);
        pulse(2, 8'h04); cyc(1);
        chk("R1 input source", {7'd0, srq}, 8'h01);
        spoll(v);
        wr_en(2, 8'h00);
        chk("R5 enable clear drops summary", query_byte, 8'h00);
        cyc(1);
        wr_en(2, 8'h04); cyc(1);
        chk("R6 rearm after enable clear", {7'd0, srq}, 8'h01);
        spoll(v); rd(2, v);
    endtask

    task automatic t_collide_std;
        logic [7:0] v;
        wr_en(5, 8'h00);
        rd_stb = 1'b1; rd_sel = 3'd0; evt_i[1] = 1'b1;
        cyc(1);
        rd_stb = 1'b0; evt_i = '0;
        rd(0, v);
        chk("R10 event kept over read", v, 8'h02);
        wr_en(4, 8'h01); wr_en(5, 8'h20);
        pulse(4, 8'h01); cyc(1);
        spoll(v);
        chk("R3 standard event at bit5", v, 8'h60);
        rd(4, v);
        chk("R3 cleared", poll_byte, 8'h00);
    endtask

    initial begin
        fork
            begin
                cyc(3); rst_n = 1'b1;
                t_reset(); t_single(); t_multi(); t_pen6(); t_enclear(); t_collide_std();
            end
            begin
                cyc(5000);
                fails++; checks++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule